// File: doc/BRIEF.md
# Serial-to-Parallel Word Deserializer with Bitslip Alignment

The block turns a single-data-rate serial stream into parallel words. On every rising edge of a fast clock it samples one bit into a shift register. Every `WIDTH` fast cycles a capture strobe copies the newest `WIDTH` bits into a holding register. A divided clock, phase-aligned with the fast clock and running at fast-clock / `WIDTH`, registers that word onto the parallel output. The bit received first lands in the most significant lane.

A receiver aligns to a known training pattern by pulsing the `bitslip` input, which is sampled on the divided clock, until the expected word appears. A slip does not rotate the captured word. It delays the next capture strobe by one fast cycle, so one serial bit is dropped and every later word boundary sits one bit further along the stream.

The boundary controller is a two-state machine. In `ST_RUN` it counts fast cycles. There are three transitions out of `ST_RUN`. COUNT stays in `ST_RUN` and advances the counter. CAPTURE stays in `ST_RUN`, fires the strobe at the last count and clears the counter. DEFER moves to `ST_SLIP`; it is taken at the last count when a slip is waiting. From `ST_SLIP`, the LATE_CAPTURE transition fires the strobe one cycle late, clears the counter and returns to `ST_RUN`. Requests cross from the divided domain as a toggle. Requests that have not yet been applied are held in a small saturating counter.

Top module: `bitslip_deser`

## Requirements
- R1: With no slip requests, one bit is taken from `din` on every rising `clk_fast` edge. Each word holds `WIDTH` consecutive stream bits, and consecutive words start exactly `WIDTH` bits apart in the stream.
- R2: The earliest-received bit of a word appears on `q[WIDTH-1]` and the latest on `q[0]`. The first word after reset release is made of the bits sampled on the first `WIDTH` rising `clk_fast` edges after release.
- R3: `q` changes only on a rising `clk_div` edge. There it shows the most recent word whose last bit was sampled on an earlier `clk_fast` edge, so `q` is constant between two `clk_div` edges.
- R4: Each rising `clk_div` edge that sees `bitslip` high requests exactly one slip. If `bitslip` is held high for N divided cycles, N slips result, applied one per word boundary.
- R5: A slip makes the next word start `WIDTH`+1 bits after the previous word. The skipped bit appears in no word, and every output word is still a contiguous window of the stream, never a rotation of a captured word.
- R6: On a stream that repeats a `WIDTH`-bit pattern (first pattern bit sent first), n slips turn the output into the pattern rotated left by n mod `WIDTH`. After `WIDTH` slips, the word boundary returns to its original phase with one whole word of the stream skipped.
- R7: `rst` is active high and asynchronous. It forces `q` to 0 without any clock edge and clears the boundary counter and any pending slips. After release, words form again as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Bit-rate clock; `din` sampled on each rising edge |
| clk_div | input | 1 | Word clock at clk_fast / WIDTH, phase-aligned |
| rst | input | 1 | Asynchronous reset, active high |
| din | input | 1 | Serial data input |
| bitslip | input | 1 | Slip request, sampled on rising clk_div |
| q | output | WIDTH | Registered parallel word, earliest bit in the MSB |

## Verification
The hardest situation to reach is a slipped word boundary drifting across a `clk_div` edge. The divided domain then registers the same word twice, while the stream itself has lost bits. This happens only after several slips, and only for some phases between the boundary and `clk_div`. To reach it, the stimulus feeds a maximal-length 6-bit sequence in which every 6-bit window is unique, so each sampled word can be placed at its exact stream position. Bursts of 1, 3 and 6 slips are then issued while `q` is sampled every divided cycle. Each step between distinct words must be `WIDTH` or `WIDTH`+1 bits, and the `WIDTH`+1 steps must add up to the number of requests.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    // Boundary controller states
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,   // counting fast cycles toward a word boundary
        ST_SLIP = 1'b1    // boundary deferred by one fast cycle
    } bnd_state_t;

endpackage

// File: rtl/bsd_shift_reg.sv
module bsd_shift_reg #(
    parameter int WIDTH = 6
) (
    input  logic             clk_fast,
    input  logic             rst,
    input  logic             din,
    output logic [WIDTH-1:0] win_next
);

    logic [WIDTH-1:0] win;

    // Newest bit enters at the LSB, so the oldest bit ends at the MSB.
    assign win_next = {win[WIDTH-2:0], din};

    always_ff @(posedge clk_fast or posedge rst) begin
        if (rst) begin
            win <= '0;
        end else begin
            win <= win_next;
        end
    end

    // One cycle after reset, the previous din must sit in the LSB
    logic live;
    always_ff @(posedge clk_fast or posedge rst) begin
        if (rst) begin
            live <= 1'b0;
        end else begin
            live <= 1'b1;
        end
    end

    p_shift_in_r1: assert property (@(posedge clk_fast) disable iff (rst)
        live |-> (win[0] == $past(din)));

endmodule

// File: rtl/bsd_slip_xfer.sv
module bsd_slip_xfer (
    input  logic clk_fast,
    input  logic clk_div,
    input  logic rst,
    input  logic bitslip,
    output logic req_pulse
);

    logic tgl_div;
    logic tgl_seen;

    // Divided domain: every sampled request flips the toggle once.
    always_ff @(posedge clk_div or posedge rst) begin
        if (rst) begin
            tgl_div <= 1'b0;
        end else if (bitslip) begin
            tgl_div <= ~tgl_div;
        end
    end

    // Fast domain: clocks are phase-aligned, so a single stage suffices.
    always_ff @(posedge clk_fast or posedge rst) begin
        if (rst) begin
            tgl_seen <= 1'b0;
        end else begin
            tgl_seen <= tgl_div;
        end
    end

    assign req_pulse = tgl_div ^ tgl_seen;

    // One request yields a single-cycle pulse in the fast domain (R4)
    p_pulse_isolated_r4: assert property (@(posedge clk_fast) disable iff (rst)
        req_pulse |=> !req_pulse);

endmodule

// File: rtl/bsd_boundary_fsm.sv
module bsd_boundary_fsm
    import bsd_pkg::*;
#(
    parameter int WIDTH      = 6,
    parameter int SLIP_CNT_W = 3
) (
    input  logic clk_fast,
    input  logic rst,
    input  logic req_pulse,
    output logic strobe
);

    localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIDTH - 1);
    localparam logic [SLIP_CNT_W-1:0] PEND_MAX = {SLIP_CNT_W{1'b1}};

    bnd_state_t              state, state_nx;
    logic [CNT_W-1:0]        cnt, cnt_nx;
    logic [SLIP_CNT_W-1:0]   pend, pend_nx;
    logic                    at_last;
    logic                    avail;
    logic                    consume;

    assign at_last = (cnt == CNT_LAST);
    assign avail   = (pend != '0) || req_pulse;

    // State register
    always_ff @(posedge clk_fast or posedge rst) begin
        if (rst) begin
            state <= ST_RUN;
            cnt   <= '0;
            pend  <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            pend  <= pend_nx;
        end
    end

    // Next state and counter
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_RUN: begin
                if (!at_last) begin
                    cnt_nx = cnt + CNT_W'(1);          // COUNT
                end else if (avail) begin
                    state_nx = ST_SLIP;                 // DEFER
                end else begin
                    cnt_nx = '0;                        // CAPTURE
                end
            end
            ST_SLIP: begin
                state_nx = ST_RUN;                      // LATE_CAPTURE
                cnt_nx   = '0;
            end
            default: begin
                state_nx = ST_RUN;
                cnt_nx   = '0;
            end
        endcase
    end

    // Outputs: capture strobe and slip consumption
    always_comb begin
        strobe  = 1'b0;
        consume = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (at_last) begin
                    strobe  = !avail;
                    consume = avail;
                end
            end
            ST_SLIP: begin
                strobe = 1'b1;
            end
            default: begin
                strobe = 1'b0;
            end
        endcase
    end

    // Pending slip counter, saturating
    always_comb begin
        pend_nx = pend;
        unique case ({req_pulse, consume})
            2'b10:   pend_nx = (pend == PEND_MAX) ? pend : pend + SLIP_CNT_W'(1);
            2'b01:   pend_nx = pend - SLIP_CNT_W'(1);
            default: pend_nx = pend;
        endcase
    end

    p_cnt_bound_r1: assert property (@(posedge clk_fast) disable iff (rst)
        cnt <= CNT_LAST);

    p_strobe_spaced_r1: assert property (@(posedge clk_fast) disable iff (rst)
        strobe |=> !strobe);

    p_slip_one_cycle_r5: assert property (@(posedge clk_fast) disable iff (rst)
        (state == ST_SLIP) |=> (state == ST_RUN) && (cnt == '0));

    p_slip_has_req_r4: assert property (@(posedge clk_fast) disable iff (rst)
        $rose(state == ST_SLIP) |-> $past((pend != '0) || req_pulse));

endmodule

// File: rtl/bsd_word_capture.sv
module bsd_word_capture #(
    parameter int WIDTH = 6
) (
    input  logic             clk_fast,
    input  logic             clk_div,
    input  logic             rst,
    input  logic             strobe,
    input  logic [WIDTH-1:0] win_next,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] hold;

    // Fast domain holding register
    always_ff @(posedge clk_fast or posedge rst) begin
        if (rst) begin
            hold <= '0;
        end else if (strobe) begin
            hold <= win_next;
        end
    end

    // Divided domain output register
    always_ff @(posedge clk_div or posedge rst) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= hold;
        end
    end

    p_q_zero_rst_r7: assert property (@(posedge clk_div)
        rst |-> (q == '0));

endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser #(
    parameter int WIDTH      = 6,
    parameter int SLIP_CNT_W = 3
) (
    input  logic             clk_fast,
    input  logic             clk_div,
    input  logic             rst,
    input  logic             din,
    input  logic             bitslip,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] win_next;
    logic             req_pulse;
    logic             strobe;

    bsd_shift_reg #(.WIDTH(WIDTH)) u_shift (
        .clk_fast (clk_fast),
        .rst      (rst),
        .din      (din),
        .win_next (win_next)
    );

    bsd_slip_xfer u_xfer (
        .clk_fast  (clk_fast),
        .clk_div   (clk_div),
        .rst       (rst),
        .bitslip   (bitslip),
        .req_pulse (req_pulse)
    );

    bsd_boundary_fsm #(.WIDTH(WIDTH), .SLIP_CNT_W(SLIP_CNT_W)) u_fsm (
        .clk_fast  (clk_fast),
        .rst       (rst),
        .req_pulse (req_pulse),
        .strobe    (strobe)
    );

    bsd_word_capture #(.WIDTH(WIDTH)) u_cap (
        .clk_fast (clk_fast),
        .clk_div  (clk_div),
        .rst      (rst),
        .strobe   (strobe),
        .win_next (win_next),
        .q        (q)
    );

endmodule

// File: tb/bitslip_deser_tb.sv
module bitslip_deser_tb;

    localparam int W    = 6;
    localparam int LOGN = 1024;

    logic         clk_fast = 1'b0;
    logic         clk_div  = 1'b0;
    logic         rst      = 1'b1;
    logic         din      = 1'b0;
    logic         bitslip  = 1'b0;
    logic [W-1:0] q;

    int tests = 0;
    int fails = 0;
    int idx   = 0;
    bit done  = 1'b0;
    bit use_lfsr = 1'b0;
    localparam logic [W-1:0] PAT = 6'b101100;

    bit logb [LOGN];
    bit mseq [63];

    // Stimulus table: {slip count, expected word on repeating PAT} (R6)
    localparam logic [9:0] SLIP_VEC [0:7] = '{
        {4'd0, 6'h2C}, {4'd1, 6'h19}, {4'd2, 6'h32}, {4'd3, 6'h25},
        {4'd4, 6'h0B}, {4'd5, 6'h16}, {4'd6, 6'h2C}, {4'd7, 6'h19}
    };

    bitslip_deser #(.WIDTH(W)) u_dut (
        .clk_fast (clk_fast),
        .clk_div  (clk_div),
        .rst      (rst),
        .din      (din),
        .bitslip  (bitslip),
        .q        (q)
    );

    // 250 MHz fast clock; divided clock rising with every W-th fast edge
    always #2 clk_fast = ~clk_fast;
    initial begin
        #2 clk_div = 1'b1;
        forever #(2*W) clk_div = ~clk_div;
    end

    function automatic bit bit_at(input int i);
        if (use_lfsr) return mseq[i % 63];
        return PAT[W-1 - (i % W)];
    endfunction

    always @(posedge clk_fast) if (!rst) idx = idx + 1;

    always @(negedge clk_fast) begin
        if (!rst) begin
            din = bit_at(idx);
            logb[idx % LOGN] = din;
        end
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Stream position whose W-bit window equals v, or -1
    function automatic int find_start(input logic [W-1:0] v);
        for (int s = idx - W; s >= 0 && s >= idx - 40; s--) begin
            logic [W-1:0] w;
            for (int k = 0; k < W; k++) w[W-1-k] = logb[(s + k) % LOGN];
            if (w == v) return s;
        end
        return -1;
    endfunction

    task automatic sample();
        @(posedge clk_div);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        bitslip = 1'b0;
        repeat (2) @(posedge clk_div);
        @(negedge clk_fast);
        #1;
        idx = 0;
        din = bit_at(0);
        logb[0] = din;
        rst = 1'b0;
    endtask

    // Issue n slips while tracking stream positions (R4, R5, R6)
    task automatic slip_burst(input int n, input string tag);
        int s_prev, s_cur, extra, bad, first;
        first  = find_start(q);
        s_prev = first;
        extra  = 0;
        bad    = 0;
        for (int k = 0; k < 16; k++) begin
            @(posedge clk_div);
            #1;
            bitslip = (k < n);
            s_cur = find_start(q);
            if (s_cur < 0) bad++;
            else if (s_cur != s_prev) begin
                if ((s_cur - s_prev) != W && (s_cur - s_prev) != W + 1) bad++;
                extra += s_cur - s_prev - W;
                s_prev = s_cur;
            end
        end
        check_eq({tag, " R5 word steps are W or W+1, windows contiguous"}, bad, 0);
        check_eq({tag, " R4 extra skipped bits equal requests"}, extra, n);
        check_eq({tag, " R6 boundary phase"}, s_prev % W, (first + n) % W);
    endtask

    initial begin
        int s0, s1;
        logic [W-1:0] q_early;
        begin
            logic [5:0] lf = 6'b000001;
            for (int i = 0; i < 63; i++) begin
                mseq[i] = lf[5];
                lf = {lf[4:0], lf[5] ^ lf[4]};
            end
        end

        // Reset state (R7)
        repeat (2) sample();
        check_eq("R7 q during reset", int'(q), 0);

        // Table walk: repeating pattern with n slips (R4, R6, R2)
        for (int i = 0; i < 8; i++) begin
            int n;
            n = int'(SLIP_VEC[i][9:6]);
            use_lfsr = 1'b0;
            do_reset();
            repeat (3) sample();
            if (n > 0) begin
                bitslip = 1'b1;
                repeat (n) @(posedge clk_div);
                #1 bitslip = 1'b0;
            end
            repeat (5) sample();
            check_eq($sformatf("R6 R4 pattern word after %0d slips", n),
                     int'(q), int'(SLIP_VEC[i][5:0]));
        end

        // Non-repeating stream, no slips (R1, R2, R3)
        use_lfsr = 1'b1;
        do_reset();
        repeat (3) sample();
        s0 = find_start(q);
        check_eq("R2 first words start on multiples of W", (s0 >= 0) ? s0 % W : -1, 0);
        for (int k = 0; k < 4; k++) begin
            sample();
            q_early = q;
            s1 = find_start(q);
            check_eq("R1 word advance without slip", s1 - s0, W);
            s0 = s1;
            #12;
            check_eq("R3 q stable within divided cycle", int'(q), int'(q_early));
        end

        // Slip bursts on a non-repeating stream
        slip_burst(1, "single");
        slip_burst(3, "triple");
        slip_burst(W, "full-word");

        // Asynchronous reset mid-cycle (R7)
        sample();
        #6;
        check_eq("R7 q nonzero before reset", int'(q != '0), 1);
        rst = 1'b1;
        #1;
        check_eq("R7 q cleared without clock", int'(q), 0);
        do_reset();
        repeat (3) sample();
        s0 = find_start(q);
        check_eq("R7 alignment restarts after reset", (s0 >= 0) ? s0 % W : -1, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_fast);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule